// File: doc/BRIEF.md
# Receive Frame Record Packer

This block sits between a receive path that delivers whole Ethernet frames as a byte stream and a host that collects them through a word-wide data port. An incoming frame is announced with a start strobe and its byte length. If the block can hold the complete record, it writes a self-describing record into an internal byte FIFO. The record is a fixed marker word, then a header word that carries the stored length and a good-status code, then the payload zero-filled up to the minimum frame size, then a freshly computed CRC-32 word, and finally zero bytes up to the next 4-byte boundary. A frame that cannot be stored whole is dropped, and a one-cycle drop pulse reports it.

The host drains records one 32-bit word at a time. Each word is presented combinationally on the data port, and a read strobe consumes it. A three-phase position tracker inside the block (marker, header, body) finds where each record ends. A frame counter reports how many complete records are waiting. A sticky interrupt flag rises whenever a record is completed. Writing zero to the frame-count port empties the FIFO.

Top module: `rxpk_top`

## Requirements
- R1: A start strobe seen while idle is accepted only when `rx_enable` is high and the free FIFO space is at least the record size. The record size is 12 + round-up-to-4(max(len, 60)) bytes. Otherwise `frame_drop` is high for the one cycle after the strobe, and nothing is stored.
- R2: A payload shorter than 60 bytes (including length 0) is followed by zero bytes up to 60 bytes.
- R3: Record word 0 is the marker 32'hA5C3_0001. In word 1, bits 15:0 hold the padded length plus 4 and bits 31:16 hold the status code 16'h0001.
- R4: After the padding comes one word holding the CRC-32 of payload plus padding. The CRC uses the reflected polynomial 0xEDB88320, an all-ones start value and a final inversion. After the CRC come zero bytes that bring the padded length to a multiple of 4.
- R5: Every word is little-endian. The earliest stored byte appears on `rd_data[7:0]`, and CRC bit 0 is in the lowest byte.
- R6: Each completed record raises `frame_cnt` by one and sets `rx_irq`. A pulse on `irq_clr` clears `rx_irq`, but a record completing in the same cycle keeps it set.
- R7: While `frame_cnt` is nonzero, `rd_data` shows the FIFO head word and `rd_req` consumes it. After the last word of a record, as given by the header length, `frame_cnt` falls by one.
- R8: While `frame_cnt` is zero, `rd_data` is 0, and `rd_req` removes nothing from the FIFO.
- R9: A `cnt_wr` carrying the value 0 empties the FIFO, clears the frame count and the read position, and abandons a record being written. A `cnt_wr` with any other value changes nothing.
- R10: `in_ready` is high only during the payload phase. Bytes offered with `in_valid` while `in_ready` is low are ignored.
- R11: The FIFO holds exactly DEPTH bytes. A record that leaves exactly zero free bytes is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Reception allowed |
| in_sof | input | 1 | Frame start strobe, qualifies `in_len` |
| in_len | input | 16 | Payload length in bytes |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte accepted this cycle when valid |
| frame_drop | output | 1 | Frame rejected (one-cycle pulse) |
| rd_req | input | 1 | Consume the current data word |
| rd_data | output | 32 | Current record word, or 0 when nothing is held |
| frame_cnt | output | CNT_W | Complete records held |
| cnt_wr | input | 1 | Write strobe for the frame-count port |
| cnt_wr_val | input | CNT_W | Value written; zero flushes |
| irq_clr | input | 1 | Clear the receive interrupt flag |
| rx_irq | output | 1 | Receive interrupt flag |

## Verification
The bench builds the block with DEPTH = 256 instead of 2048. At that size, records of a few hundred bytes are enough to fill the FIFO. A 172-byte frame followed by a 60-byte frame fills it to the last byte, and a 61-byte frame at that point falls short by four bytes. Both the exact-fit acceptance and the just-too-big rejection can therefore be hit directly. The same depth keeps every record short, so each one is compared word by word against a CRC and layout model in the bench.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    localparam logic [31:0] MARKER_WORD = 32'hA5C3_0001;
    localparam logic [15:0] STATUS_OK   = 16'h0001;
    localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
    localparam logic [15:0] MIN_PAYLOAD = 16'd60;
    localparam logic [17:0] FIXED_BYTES = 18'd12;

    typedef enum logic [2:0] {
        PK_IDLE,
        PK_MARK,
        PK_HDR,
        PK_DATA,
        PK_PAD,
        PK_CRC,
        PK_ALIGN
    } pk_state_e;

    typedef enum logic [1:0] {
        RD_MARK,
        RD_HDR,
        RD_BODY
    } rd_phase_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_wr_t;

    function automatic logic [15:0] padded_len(input logic [15:0] len);
        return (len < MIN_PAYLOAD) ? MIN_PAYLOAD : len;
    endfunction

    function automatic logic [17:0] round_up4(input logic [17:0] v);
        logic [17:0] s;
        s = v + 18'd3;
        return {s[17:2], 2'b00};
    endfunction

    function automatic logic [17:0] record_bytes(input logic [15:0] len);
        return FIXED_BYTES + round_up4({2'b00, padded_len(len)});
    endfunction

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxpk_fifo.sv
module rxpk_fifo
    import rxpk_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  byte_wr_t      wr,
    input  logic          pop,
    output logic [31:0]   head,
    output logic [AW:0]   used
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_wr;

    assign do_wr = wr.valid && !flush;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= rd_ptr + AW'(4);
            end
            used <= used + (AW+1)'(do_wr) - (pop ? (AW+1)'(4) : '0);
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign head[8*k +: 8] = mem[rd_ptr + AW'(k)];
    end

endmodule

// File: rtl/rxpk_packer.sv
module rxpk_packer
    import rxpk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        rx_enable,
    input  logic        in_sof,
    input  logic [15:0] in_len,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic [17:0] free_space,
    output logic        in_ready,
    output logic        frame_drop,
    output logic        done,
    output logic        idle,
    output byte_wr_t    wr
);

    pk_state_e   state;
    logic [1:0]  idx;
    logic [15:0] len_q;
    logic [15:0] pad_q;
    logic [15:0] pos;
    logic [31:0] crc;
    logic [1:0]  align_q;
    logic [31:0] hdr_word;
    logic [31:0] crc_out;
    logic        fits;

    assign hdr_word = {STATUS_OK, pad_q + 16'd4};
    assign crc_out  = ~crc;
    assign fits     = rx_enable && (free_space >= record_bytes(in_len));
    assign in_ready = (state == PK_DATA);
    assign idle     = (state == PK_IDLE);

    always_comb begin
        wr = '0;
        unique case (state)
            PK_MARK:  wr = '{valid: 1'b1, data: MARKER_WORD[{idx, 3'b000} +: 8]};
            PK_HDR:   wr = '{valid: 1'b1, data: hdr_word[{idx, 3'b000} +: 8]};
            PK_DATA:  wr = '{valid: in_valid, data: in_data};
            PK_PAD:   wr = '{valid: 1'b1, data: 8'h00};
            PK_CRC:   wr = '{valid: 1'b1, data: crc_out[{idx, 3'b000} +: 8]};
            PK_ALIGN: wr = '{valid: 1'b1, data: 8'h00};
            default:  wr = '0;
        endcase
    end

    always_comb begin
        done = 1'b0;
        if (!flush) begin
            if (state == PK_CRC && idx == 2'd3 && align_q == 2'd0) begin
                done = 1'b1;
            end else if (state == PK_ALIGN && align_q == 2'd1) begin
                done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state      <= PK_IDLE;
            idx        <= '0;
            len_q      <= '0;
            pad_q      <= '0;
            pos        <= '0;
            crc        <= '1;
            align_q    <= '0;
            frame_drop <= 1'b0;
        end else begin
            frame_drop <= 1'b0;
            unique case (state)
                PK_IDLE: begin
                    if (in_sof) begin
                        if (fits) begin
                            state   <= PK_MARK;
                            idx     <= '0;
                            len_q   <= in_len;
                            pad_q   <= padded_len(in_len);
                            pos     <= '0;
                            crc     <= '1;
                            align_q <= 2'(2'd0 - padded_len(in_len)[1:0]);
                        end else begin
                            frame_drop <= 1'b1;
                        end
                    end
                end
                PK_MARK: begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd3) begin
                        state <= PK_HDR;
                    end
                end
                PK_HDR: begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd3) begin
                        state <= (len_q == 16'd0) ? PK_PAD : PK_DATA;
                    end
                end
                PK_DATA: begin
                    if (in_valid) begin
                        crc <= crc_step(crc, in_data);
                        pos <= pos + 16'd1;
                        if (pos + 16'd1 == len_q) begin
                            state <= (len_q < MIN_PAYLOAD) ? PK_PAD : PK_CRC;
                        end
                    end
                end
                PK_PAD: begin
                    crc <= crc_step(crc, 8'h00);
                    pos <= pos + 16'd1;
                    if (pos + 16'd1 == pad_q) begin
                        state <= PK_CRC;
                    end
                end
                PK_CRC: begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd3) begin
                        state <= (align_q != 2'd0) ? PK_ALIGN : PK_IDLE;
                    end
                end
                PK_ALIGN: begin
                    align_q <= align_q - 2'd1;
                    if (align_q == 2'd1) begin
                        state <= PK_IDLE;
                    end
                end
                default: state <= PK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxpk_reader.sv
module rxpk_reader
    import rxpk_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             rd_req,
    input  logic [31:0]      head,
    input  logic             frame_inc,
    output logic             pop,
    output logic [31:0]      rd_data,
    output logic [CNT_W-1:0] frame_cnt
);

    rd_phase_e   phase;
    logic [17:0] remain;
    logic        frame_dec;

    assign pop     = rd_req && (frame_cnt != '0);
    assign rd_data = (frame_cnt != '0) ? head : 32'd0;

    always_comb begin
        frame_dec = 1'b0;
        if (pop && phase == RD_BODY && remain == 18'd4) begin
            frame_dec = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            phase     <= RD_MARK;
            remain    <= '0;
            frame_cnt <= '0;
        end else begin
            if (pop) begin
                unique case (phase)
                    RD_MARK: phase <= RD_HDR;
                    RD_HDR: begin
                        phase  <= RD_BODY;
                        remain <= round_up4({2'b00, head[15:0]});
                    end
                    RD_BODY: begin
                        remain <= remain - 18'd4;
                        if (remain == 18'd4) begin
                            phase <= RD_MARK;
                        end
                    end
                    default: phase <= RD_MARK;
                endcase
            end
            frame_cnt <= frame_cnt + CNT_W'(frame_inc) - CNT_W'(frame_dec);
        end
    end

endmodule

// File: rtl/rxpk_top.sv
module rxpk_top
    import rxpk_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int CNT_W = AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_enable,
    input  logic             in_sof,
    input  logic [15:0]      in_len,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             frame_drop,
    input  logic             rd_req,
    output logic [31:0]      rd_data,
    output logic [CNT_W-1:0] frame_cnt,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wr_val,
    input  logic             irq_clr,
    output logic             rx_irq
);

    byte_wr_t     wr;
    logic         flush;
    logic         done;
    logic         pk_idle;
    logic         pop;
    logic [31:0]  head;
    logic [AW:0]  fifo_used;
    logic [17:0]  free_space;

    assign flush      = cnt_wr && (cnt_wr_val == '0);
    assign free_space = 18'(DEPTH) - 18'(fifo_used);

    rxpk_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .rx_enable  (rx_enable),
        .in_sof     (in_sof),
        .in_len     (in_len),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .free_space (free_space),
        .in_ready   (in_ready),
        .frame_drop (frame_drop),
        .done       (done),
        .idle       (pk_idle),
        .wr         (wr)
    );

    rxpk_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .wr    (wr),
        .pop   (pop),
        .head  (head),
        .used  (fifo_used)
    );

    rxpk_reader #(.CNT_W(CNT_W)) u_read (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .rd_req    (rd_req),
        .head      (head),
        .frame_inc (done),
        .pop       (pop),
        .rd_data   (rd_data),
        .frame_cnt (frame_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_irq <= 1'b0;
        end else if (done) begin
            rx_irq <= 1'b1;
        end else if (irq_clr) begin
            rx_irq <= 1'b0;
        end
    end

endmodule

// File: rtl/rxpk_chk.sv
module rxpk_chk #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int CNT_W = AW
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_enable,
    input logic             in_sof,
    input logic             rd_req,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wr_val,
    input logic [CNT_W-1:0] frame_cnt,
    input logic             frame_drop,
    input logic             rx_irq,
    input logic [AW:0]      fifo_used,
    input logic             pk_idle
);

    logic flushing;
    assign flushing = cnt_wr && (cnt_wr_val == '0);

    p_drop_disabled_r1: assert property (@(posedge clk) disable iff (rst)
        (pk_idle && in_sof && !rx_enable && !flushing) |=> frame_drop);

    p_irq_on_store_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_cnt == $past(frame_cnt) + CNT_W'(1)) |-> rx_irq);

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
        !flushing |=> ((frame_cnt == $past(frame_cnt))
                    || (frame_cnt == $past(frame_cnt) + CNT_W'(1))
                    || (frame_cnt == $past(frame_cnt) - CNT_W'(1))));

    p_empty_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && frame_cnt == '0 && !flushing) |=> (fifo_used >= $past(fifo_used)));

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
        flushing |=> (frame_cnt == '0 && fifo_used == '0 && pk_idle));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_used <= (AW+1)'(DEPTH));

endmodule

bind rxpk_top rxpk_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_enable  (rx_enable),
    .in_sof     (in_sof),
    .rd_req     (rd_req),
    .cnt_wr     (cnt_wr),
    .cnt_wr_val (cnt_wr_val),
    .frame_cnt  (frame_cnt),
    .frame_drop (frame_drop),
    .rx_irq     (rx_irq),
    .fifo_used  (fifo_used),
    .pk_idle    (pk_idle)
);

// File: tb/sim_rxpk_top.sv
module sim_rxpk_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;
    localparam int CNT_W = $clog2(DEPTH);
    localparam int NVEC = 8;

    // {len, seed, noise}
    localparam logic [24:0] VECS [NVEC] = '{
        {16'd0,   8'h11, 1'b0},
        {16'd1,   8'h22, 1'b1},
        {16'd59,  8'h33, 1'b0},
        {16'd60,  8'h44, 1'b1},
        {16'd61,  8'h55, 1'b0},
        {16'd62,  8'h66, 1'b0},
        {16'd63,  8'h77, 1'b1},
        {16'd127, 8'h88, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_enable = 1'b0;
    logic             in_sof = 1'b0;
    logic [15:0]      in_len = '0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_ready;
    logic             frame_drop;
    logic             rd_req = 1'b0;
    logic [31:0]      rd_data;
    logic [CNT_W-1:0] frame_cnt;
    logic             cnt_wr = 1'b0;
    logic [CNT_W-1:0] cnt_wr_val = '0;
    logic             irq_clr = 1'b0;
    logic             rx_irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] fb  [512];
    logic [7:0] rec [1024];
    int         rec_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxpk_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .in_sof(in_sof),
        .in_len(in_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .frame_drop(frame_drop), .rd_req(rd_req),
        .rd_data(rd_data), .frame_cnt(frame_cnt), .cnt_wr(cnt_wr),
        .cnt_wr_val(cnt_wr_val), .irq_clr(irq_clr), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic build(input int len, input logic [7:0] seed);
        int pad;
        int n;
        logic [31:0] c;
        logic [31:0] hdr;
        pad = (len < 60) ? 60 : len;
        for (int i = 0; i < len; i++) fb[i] = seed + 8'(i * 7);
        hdr = {16'h0001, 16'(pad + 4)};
        n = 0;
        for (int i = 0; i < 4; i++) begin rec[n] = 8'(32'hA5C3_0001 >> (8*i)); n++; end
        for (int i = 0; i < 4; i++) begin rec[n] = 8'(hdr >> (8*i)); n++; end
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < pad; i++) begin
            rec[n] = (i < len) ? fb[i] : 8'h00;
            c = model_crc(c, rec[n]);
            n++;
        end
        c = ~c;
        for (int i = 0; i < 4; i++) begin rec[n] = 8'(c >> (8*i)); n++; end
        while ((n % 4) != 0) begin rec[n] = 8'h00; n++; end
        rec_len = n;
    endtask

    task automatic send(input int len, input logic [7:0] seed, input logic noise,
                        output logic dropped);
        int i;
        build(len, seed);
        @(negedge clk);
        in_sof = 1'b1;
        in_len = 16'(len);
        @(negedge clk);
        in_sof = 1'b0;
        dropped = frame_drop;
        if (!dropped) begin
            i = 0;
            while (i < len) begin
                @(negedge clk);
                if (in_ready) begin
                    in_valid = 1'b1;
                    in_data  = fb[i];
                    i++;
                end else begin
                    in_valid = noise;
                    in_data  = 8'hEE;
                end
            end
            repeat (90) begin
                @(negedge clk);
                in_valid = noise;
                in_data  = 8'hEE;
            end
            in_valid = 1'b0;
        end
    endtask

    task automatic read_record(input int len, input logic [7:0] seed, input int nwords,
                               input string req);
        build(len, seed);
        for (int w = 0; w < nwords && w < rec_len / 4; w++) begin
            chk(req, rd_data, {rec[4*w+3], rec[4*w+2], rec[4*w+1], rec[4*w]});
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
        end
    endtask

    task automatic pulse_cnt_wr(input logic [CNT_W-1:0] v);
        @(negedge clk);
        cnt_wr = 1'b1;
        cnt_wr_val = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R7 reset frame_cnt", 32'(frame_cnt), 0);
        chk("R6 reset rx_irq", 32'(rx_irq), 0);
        chk("R8 reset rd_data", rd_data, 0);
        chk("R10 reset in_ready", 32'(in_ready), 0);

        // R1: reception disabled
        send(10, 8'h01, 1'b0, d);
        chk("R1 drop when disabled", 32'(d), 1);
        chk("R1 nothing stored", 32'(frame_cnt), 0);

        // R8: reads while empty return 0 and pop nothing
        rx_enable = 1'b1;
        rd_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 empty read data", rd_data, 0);
        rd_req = 1'b0;

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            send(int'(VECS[v][24:9]), VECS[v][8:1], VECS[v][0], d);
            chk("R1 accepted", 32'(d), 0);
            chk("R6 count after store", 32'(frame_cnt), 1);
            chk("R6 irq after store", 32'(rx_irq), 1);
            read_record(int'(VECS[v][24:9]), VECS[v][8:1], 1000, "R2 R3 R4 R5 R10 record");
            chk("R7 count after drain", 32'(frame_cnt), 0);
            @(negedge clk);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            chk("R6 irq cleared", 32'(rx_irq), 0);
        end

        // R11: exact fit and just-too-big
        send(172, 8'h90, 1'b0, d);
        chk("R11 first frame accepted", 32'(d), 0);
        send(61, 8'hA0, 1'b0, d);
        chk("R1 R11 short of space dropped", 32'(d), 1);
        chk("R1 count unchanged", 32'(frame_cnt), 1);
        send(60, 8'hB0, 1'b0, d);
        chk("R11 exact fit accepted", 32'(d), 0);
        chk("R7 two frames held", 32'(frame_cnt), 2);
        read_record(172, 8'h90, 1000, "R7 first of two");
        chk("R7 count after first", 32'(frame_cnt), 1);
        read_record(60, 8'hB0, 1000, "R7 second of two");
        chk("R7 count after second", 32'(frame_cnt), 0);

        // R9: nonzero write ignored, zero write flushes
        send(20, 8'hC0, 1'b0, d);
        send(70, 8'hD0, 1'b0, d);
        pulse_cnt_wr(CNT_W'(5));
        chk("R9 nonzero write ignored", 32'(frame_cnt), 2);
        read_record(20, 8'hC0, 1000, "R9 data intact after nonzero write");
        pulse_cnt_wr('0);
        chk("R9 flush clears count", 32'(frame_cnt), 0);
        chk("R9 flush empties data", rd_data, 0);

        // R9: flush mid-record resets read position
        send(40, 8'hE0, 1'b0, d);
        read_record(40, 8'hE0, 3, "R9 partial read");
        pulse_cnt_wr('0);
        send(33, 8'hF0, 1'b0, d);
        read_record(33, 8'hF0, 1000, "R9 record after partial flush");
        chk("R9 count after partial flush case", 32'(frame_cnt), 0);

        // R9: flush abandons a record being written
        @(negedge clk);
        in_sof = 1'b1;
        in_len = 16'd100;
        @(negedge clk);
        in_sof = 1'b0;
        repeat (5) @(negedge clk);
        pulse_cnt_wr('0);
        repeat (150) @(negedge clk);
        chk("R9 abandoned record not counted", 32'(frame_cnt), 0);
        send(64, 8'h5A, 1'b0, d);
        read_record(64, 8'h5A, 1000, "R9 record after abandon");

        // R6: completion beats a simultaneous clear is covered by assertion; plain clear here
        chk("R6 irq set by last frame", 32'(rx_irq), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule